// File: doc/BRIEF.md
# Lock-Aware 64-Slot Translation Buffer

This block holds a small fully associative translation buffer: every slot keeps a tag word and an entry word. Bit 63 of an entry word marks the slot valid and bit 6 marks it locked. A command port on the block runs all upkeep. Software can load a new mapping and let the block pick the slot, or it can write a slot by number. It can look up a tag, read back a slot, read and write a small register file, and change the translation enable bits.

An automatic load first uses the lowest-numbered slot that is not valid. When every slot is valid, it evicts the lowest-numbered slot that is not locked. When every slot is both valid and locked, the load is dropped. Both kinds of load take their tag from the tag-access register. A write that changes the enable bits schedules a flush that clears every valid bit in the next cycle. A load arriving in that same cycle is placed after the flush.

Top module: `tbuf_unit`

## Requirements
- R1: After reset no response is pending, `en_bits` is 0, every slot reads back as zero and a tag search returns zero.
- R2: An automatic load (op 1) writes the lowest-numbered slot whose entry bit 63 is clear.
- R3: When all slots are valid, an automatic load writes the lowest-numbered slot whose entry bit 6 is clear.
- R4: When every slot has both bit 63 and bit 6 set, an automatic load changes no slot.
- R5: Every load, automatic or direct, stores `cmd_wdata` as the entry and the current value of register 6 (the tag-access register) as the tag.
- R6: A direct write (op 2) and an index read (op 7) select the slot from `cmd_addr[8:3]`, and other address bits are ignored.
- R7: A tag search (op 3) with key `cmd_wdata` returns the stored tag of the lowest-numbered valid slot whose tag equals the key, or zero when no valid slot matches.
- R8: A register write (op 4) and a register read (op 5) select one of 16 64-bit registers from `cmd_addr[6:3]`. A read returns the last value written.
- R9: A write to register 3 with `cmd_wdata[0]` clear sets both register 3 and register 4 to zero. With bit 0 set, it stores the value in register 3 only.
- R10: An enable write (op 6) copies `cmd_wdata[1:0]` to `en_bits`. If the value changes, every slot loses its valid bit. If the value is unchanged, the slots are untouched.
- R11: The invalidation takes effect in the cycle after the enable write. An automatic load issued in that cycle is applied after it, so the load lands in slot 0 and stays valid.
- R12: Ops 3, 5 and 7 raise `rsp_valid` with `rsp_data` for exactly one cycle, one clock after the command. Ops 0, 1, 2, 4 and 6 produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 auto load, 2 direct write, 3 search, 4 register write, 5 register read, 6 enable write, 7 index read) |
| cmd_addr | input | 16 | Slot index in bits 8:3, register index in bits 6:3 |
| cmd_wdata | input | 64 | Entry data, register data, search key or enable value |
| rsp_valid | output | 1 | Read or search result valid |
| rsp_data | output | 64 | Read or search result |
| en_bits | output | 2 | Current translation enable bits |

## Verification
Every command is sampled on one rising edge, and its result is registered on that same edge. A search or read result is therefore visible one cycle later. The bench drives each command at a falling edge and reads the result at the next falling edge. A write becomes visible to the next command. The flush set off by an enable change lands one cycle after the enable write. The bench issues the following load back to back, so that the load meets the flush in the same cycle, and then inspects the slots by reads and searches.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_FILL   = 3'd1,
      OP_WRIDX  = 3'd2,
      OP_SEARCH = 3'd3,
      OP_REGWR  = 3'd4,
      OP_REGRD  = 3'd5,
      OP_ENWR   = 3'd6,
      OP_RDIDX  = 3'd7
   } tbuf_op_e;
endpackage

// File: rtl/tbuf_prio.sv
module tbuf_prio #(
   parameter int N  = 64,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/tbuf_regs.sv
module tbuf_regs #(
   parameter int DW      = 64,
   parameter int NREGS   = 16,
   parameter int RIW     = 4,
   parameter int TAG_REG = 6,
   parameter int FSR_REG = 3,
   parameter int FAR_REG = 4,
   parameter int EN_W    = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [RIW-1:0] idx,
   input  logic [DW-1:0]  wdata,
   input  logic           en_wr,
   output logic [DW-1:0]  rd_data,
   output logic [DW-1:0]  tag_acc,
   output logic [EN_W-1:0] en_bits,
   output logic           flush
);
   logic [DW-1:0] regs_q [NREGS];
   logic          fsr_clear;

   assign fsr_clear = wr && (idx == RIW'(FSR_REG)) && !wdata[0];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[g] <= '0;
         end else if (fsr_clear) begin
            if (g == FSR_REG || g == FAR_REG) regs_q[g] <= '0;
         end else if (wr && idx == RIW'(g)) begin
            regs_q[g] <= wdata;
         end
      end
   end

   assign rd_data = regs_q[idx];
   assign tag_acc = regs_q[TAG_REG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_bits <= '0;
         flush   <= 1'b0;
      end else begin
         flush <= en_wr && (wdata[EN_W-1:0] != en_bits);
         if (en_wr) en_bits <= wdata[EN_W-1:0];
      end
   end

   // R9: a clearing write to the status register empties status and address
   assert_fsr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fsr_clear |=> (regs_q[FSR_REG] == '0) && (regs_q[FAR_REG] == '0));

   // R10: a changed enable value always schedules a flush
   assert_en_change_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && wdata[EN_W-1:0] != en_bits) |=> flush);

   // R10: an unchanged enable value never schedules a flush
   assert_en_same_noflush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && wdata[EN_W-1:0] == en_bits) |=> !flush);
endmodule

// File: rtl/tbuf_array.sv
module tbuf_array #(
   parameter int ENTRIES    = 64,
   parameter int DW         = 64,
   parameter int VALID_BIT  = 63,
   parameter int LOCK_BIT   = 6,
   parameter bit LOCK_AWARE = 1'b1,
   parameter int SIW        = $clog2(ENTRIES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush,
   input  logic           fill,
   input  logic           wr_idx,
   input  logic [SIW-1:0] slot,
   input  logic [DW-1:0]  wdata,
   input  logic [DW-1:0]  tag_acc,
   output logic [DW-1:0]  search_tag,
   output logic [DW-1:0]  slot_data
);
   logic [DW-1:0]      tte_q [ENTRIES];
   logic [DW-1:0]      tag_q [ENTRIES];
   logic [ENTRIES-1:0] valid_vec, lock_vec, valid_eff, match_vec;
   logic               free_found, unl_found, hit_found;
   logic [SIW-1:0]     free_idx, unl_idx, hit_idx, pick;
   logic               do_fill;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_vec
      assign valid_vec[i] = tte_q[i][VALID_BIT];
      assign lock_vec[i]  = tte_q[i][LOCK_BIT];
      assign match_vec[i] = valid_eff[i] && (tag_q[i] == wdata);
   end
   assign valid_eff = flush ? '0 : valid_vec;

   tbuf_prio #(.N(ENTRIES), .IW(SIW)) u_free (
      .req(~valid_eff), .found(free_found), .idx(free_idx));

   if (LOCK_AWARE) begin : g_lock
      tbuf_prio #(.N(ENTRIES), .IW(SIW)) u_unl (
         .req(~lock_vec), .found(unl_found), .idx(unl_idx));
   end else begin : g_nolock
      assign unl_found = 1'b1;
      assign unl_idx   = '0;
   end

   tbuf_prio #(.N(ENTRIES), .IW(SIW)) u_hit (
      .req(match_vec), .found(hit_found), .idx(hit_idx));

   assign pick    = free_found ? free_idx : unl_idx;
   assign do_fill = fill && (free_found || unl_found);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic wr_here;
      assign wr_here = (do_fill && pick == SIW'(i)) || (wr_idx && slot == SIW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tte_q[i] <= '0;
            tag_q[i] <= '0;
         end else begin
            if (flush) tte_q[i][VALID_BIT] <= 1'b0;
            if (wr_here) begin
               tte_q[i] <= wdata;
               tag_q[i] <= tag_acc;
            end
         end
      end
   end

   assign search_tag = hit_found ? tag_q[hit_idx] : '0;

   always_comb begin
      slot_data = tte_q[slot];
      slot_data[VALID_BIT] = valid_eff[slot];
   end

   // R4: a load with no free and no unlocked slot leaves every slot as it was
   assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill && !flush && (&valid_vec) && (&lock_vec)) |=>
         ($stable(valid_vec) && $stable(lock_vec)));

   // R11: after a flush at most the slot of a concurrent load remains valid
   assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ($countones(valid_vec) <= 1));

   // R2: an invalid slot is always available to a load after a flush
   assert_flush_fill_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && fill) |=> valid_vec[0]);
endmodule

// File: rtl/tbuf_unit.sv
module tbuf_unit
   import tbuf_pkg::*;
#(
   parameter int ENTRIES    = 64,
   parameter int DW         = 64,
   parameter int AW         = 16,
   parameter int VALID_BIT  = 63,
   parameter int LOCK_BIT   = 6,
   parameter int NREGS      = 16,
   parameter int TAG_REG    = 6,
   parameter int FSR_REG    = 3,
   parameter int FAR_REG    = 4,
   parameter int EN_W       = 2,
   parameter int IDX_LSB    = 3,
   parameter bit LOCK_AWARE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [2:0]      cmd_op,
   input  logic [AW-1:0]   cmd_addr,
   input  logic [DW-1:0]   cmd_wdata,
   output logic            rsp_valid,
   output logic [DW-1:0]   rsp_data,
   output logic [EN_W-1:0] en_bits
);
   localparam int SIW = $clog2(ENTRIES);
   localparam int RIW = $clog2(NREGS);

   if (ENTRIES != (1 << SIW)) begin : g_bad_entries
      $error("ENTRIES must be a power of two");
   end
   if (VALID_BIT >= DW || LOCK_BIT >= DW || VALID_BIT == LOCK_BIT) begin : g_bad_bits
      $error("valid and lock bits must be distinct and inside the entry");
   end
   if (IDX_LSB + SIW > AW || IDX_LSB + RIW > AW) begin : g_bad_addr
      $error("index fields exceed the address width");
   end
   if (TAG_REG >= NREGS || FSR_REG >= NREGS || FAR_REG >= NREGS || EN_W > DW) begin : g_bad_regs
      $error("register numbers out of range");
   end

   tbuf_op_e        op;
   logic            is_fill, is_wridx, is_regwr, is_enwr, is_resp;
   logic [SIW-1:0]  slot;
   logic [RIW-1:0]  ridx;
   logic [DW-1:0]   reg_rd, tag_acc, search_tag, slot_data;
   logic            flush;

   assign op       = tbuf_op_e'(cmd_op);
   assign is_fill  = cmd_valid && op == OP_FILL;
   assign is_wridx = cmd_valid && op == OP_WRIDX;
   assign is_regwr = cmd_valid && op == OP_REGWR;
   assign is_enwr  = cmd_valid && op == OP_ENWR;
   assign is_resp  = cmd_valid && (op == OP_SEARCH || op == OP_REGRD || op == OP_RDIDX);
   assign slot     = cmd_addr[IDX_LSB +: SIW];
   assign ridx     = cmd_addr[IDX_LSB +: RIW];

   tbuf_regs #(
      .DW(DW), .NREGS(NREGS), .RIW(RIW), .TAG_REG(TAG_REG),
      .FSR_REG(FSR_REG), .FAR_REG(FAR_REG), .EN_W(EN_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(is_regwr), .idx(ridx), .wdata(cmd_wdata),
      .en_wr(is_enwr), .rd_data(reg_rd), .tag_acc(tag_acc),
      .en_bits(en_bits), .flush(flush));

   tbuf_array #(
      .ENTRIES(ENTRIES), .DW(DW), .VALID_BIT(VALID_BIT), .LOCK_BIT(LOCK_BIT),
      .LOCK_AWARE(LOCK_AWARE), .SIW(SIW)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .flush(flush), .fill(is_fill), .wr_idx(is_wridx),
      .slot(slot), .wdata(cmd_wdata), .tag_acc(tag_acc),
      .search_tag(search_tag), .slot_data(slot_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= is_resp;
         if (is_resp) begin
            case (op)
               OP_SEARCH: rsp_data <= search_tag;
               OP_REGRD:  rsp_data <= reg_rd;
               default:   rsp_data <= slot_data;
            endcase
         end
      end
   end

   // R12: a read or search command is answered on the next cycle
   assert_resp_next_R12: assert property (@(posedge clk) disable iff (!rst_n)
      is_resp |=> rsp_valid);

   // R12: commands without a result raise no response
   assert_no_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_valid || !is_resp) |=> !rsp_valid);
endmodule

// File: tb/tbuf_unit_test.sv
module tbuf_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] VB = 64'h8000_0000_0000_0000;
   localparam logic [63:0] LK = 64'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [15:0] cmd_addr = '0;
   logic [63:0] cmd_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic [1:0]  en_bits;

   int n_checks = 0;
   int n_fail   = 0;

   tbuf_unit uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .en_bits(en_bits));

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge with the result visible
   task automatic issue(logic [2:0] op, logic [15:0] addr, logic [63:0] data);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = addr;
      cmd_wdata = data;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 3'd0;
   endtask

   task automatic reg_wr(int r, logic [63:0] d);
      issue(3'd4, 16'(r << 3), d);
   endtask

   task automatic reg_rd_chk(string req, int r, logic [63:0] exp);
      issue(3'd5, 16'(r << 3), 64'h0);
      chk(req, {63'h0, rsp_valid}, 64'h1);
      chk(req, rsp_data, exp);
   endtask

   task automatic search_chk(string req, logic [63:0] key, logic [63:0] exp);
      issue(3'd3, 16'h0, key);
      chk(req, {63'h0, rsp_valid}, 64'h1);
      chk(req, rsp_data, exp);
   endtask

   task automatic slot_chk(string req, int s, logic [63:0] exp);
      issue(3'd7, 16'(s << 3), 64'h0);
      chk(req, rsp_data, exp);
   endtask

   task automatic fill(logic [63:0] tag, logic [63:0] d);
      reg_wr(6, tag);
      issue(3'd1, 16'h0, d);
   endtask

   task automatic t_reset();
      chk("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
      chk("R1 en_bits", {62'h0, en_bits}, 64'h0);
      slot_chk("R1 slot0", 0, 64'h0);
      slot_chk("R1 slot63", 63, 64'h0);
      search_chk("R1 search", 64'h0, 64'h0);
   endtask

   task automatic t_regs();
      issue(3'd4, 16'h00B7, 64'h1234_5678_9ABC_DEF0);
      chk("R12 no resp on write", {63'h0, rsp_valid}, 64'h0);
      reg_rd_chk("R8 reg6 via addr 6:3", 6, 64'h1234_5678_9ABC_DEF0);
      reg_wr(9, 64'hCAFE);
      reg_rd_chk("R8 reg9", 9, 64'hCAFE);
   endtask

   task automatic t_fsr();
      reg_wr(4, 64'hABC);
      reg_wr(3, 64'h55);
      reg_rd_chk("R9 fsr set stores", 3, 64'h55);
      reg_rd_chk("R9 far kept", 4, 64'hABC);
      reg_wr(3, 64'h2);
      reg_rd_chk("R9 fsr cleared", 3, 64'h0);
      reg_rd_chk("R9 far cleared", 4, 64'h0);
   endtask

   task automatic t_fill();
      fill(64'h11, VB | 64'h1);
      fill(64'h22, VB | 64'h2);
      fill(64'h33, VB | 64'h3);
      chk("R12 no resp on fill", {63'h0, rsp_valid}, 64'h0);
      slot_chk("R2 slot1", 1, VB | 64'h2);
      search_chk("R5 tag from reg6", 64'h22, 64'h22);
      issue(3'd2, 16'(1 << 3), 64'h5);
      search_chk("R7 invalid slot no match", 64'h22, 64'h0);
      search_chk("R7 valid match", 64'h33, 64'h33);
      fill(64'h44, VB | 64'h4);
      slot_chk("R2 lowest invalid reused", 1, VB | 64'h4);
      slot_chk("R2 slot3 untouched", 3, 64'h0);
      issue(3'd2, 16'((5 << 3) | (1 << 9) | 3), VB | 64'h55);
      slot_chk("R6 slot5 direct", 5, VB | 64'h55);
      slot_chk("R6 slot37 untouched", 37, 64'h0);
      search_chk("R7 miss", 64'h9999, 64'h0);
   endtask

   task automatic t_enable();
      issue(3'd6, 16'h0, 64'h1);
      chk("R10 en_bits", {62'h0, en_bits}, 64'h1);
      search_chk("R10 flushed", 64'h33, 64'h0);
      slot_chk("R10 entry kept, valid cleared", 2, 64'h3);
      fill(64'h66, VB | 64'h6);
      issue(3'd6, 16'h0, 64'h1);
      search_chk("R10 same value no flush", 64'h66, 64'h66);
   endtask

   task automatic t_flush_fill();
      reg_wr(6, 64'h99);
      issue(3'd6, 16'h0, 64'h3);
      issue(3'd1, 16'h0, VB | 64'h9);
      slot_chk("R11 fill after flush in slot0", 0, VB | 64'h9);
      search_chk("R11 new tag valid", 64'h99, 64'h99);
      search_chk("R11 old tag flushed", 64'h66, 64'h0);
   endtask

   task automatic t_full();
      issue(3'd6, 16'h0, 64'h0);
      for (int i = 0; i < 64; i++) begin
         reg_wr(6, 64'(64'h1000 + i));
         issue(3'd2, 16'(i << 3), (i == 10) ? (VB | 64'(i)) : (VB | LK | 64'(i)));
      end
      fill(64'h7777, VB | LK | 64'hAA);
      slot_chk("R3 unlocked slot replaced", 10, VB | LK | 64'hAA);
      search_chk("R3 new tag", 64'h7777, 64'h7777);
      search_chk("R3 old tag gone", 64'h100A, 64'h0);
      fill(64'h8888, VB | 64'hBB);
      search_chk("R4 drop no tag", 64'h8888, 64'h0);
      slot_chk("R4 slot0 unchanged", 0, VB | LK);
      slot_chk("R4 slot63 unchanged", 63, VB | LK | 64'd63);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_fsr();
      t_fill();
      t_enable();
      t_flush_fill();
      t_full();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule